// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Core

This block gathers 64 level-sensitive interrupt inputs and drives two processor request lines. One is a normal request line that is gated by per-source priority. The other is a fast request line that has no priority. Software controls the block through a 32-bit, word-addressed register interface. Through it, software sets which sources are enabled and which are fast, gives each source a 4-bit priority, and sets a threshold mask for normal requests. It can also force the pending state directly.

Each source has a pending bit. A rising input sets it and a falling input clears it. A source counts as qualified when it is pending and enabled. Each qualified source is either fast or normal, according to its type bit.

Two status words act as acknowledge words. Reading the normal one returns the winning normal source and its priority. Reading the fast one returns the lowest-numbered fast source. Either read also clears the returned source's pending bit in the same cycle.

Top module: `vic_core`

## Requirements
- R1: An input going 0→1 sets that source's pending bit and an input going 1→0 clears it; both take effect at the next clock edge. When a status-word read clears a source in the same cycle as its input rises, the clear wins.
- R2: Writing word 2 sets the enable bit whose index is `wdata[5:0]`. Writing word 3 clears that bit. Both words read as 0.
- R3: The 64-bit vectors are readable as a high word followed by a low word. Enable is at words 4/5 (read and write), type is at words 6/7 (read and write, 1 = fast), and raw pending is at words 18/19 (read only).
- R4: Word 0 is a control word. On a write it keeps only bits 24, 22, 21, 20, 19 and 18, and all other bits read back as 0.
- R5: Word 1 holds a 5-bit normal mask that resets to 31. While the mask is 31, `irq_norm` is high exactly when some normal source is qualified.
- R6: While the mask is below 31, `irq_norm` is high only when a qualified normal source has a priority strictly greater than the mask.
- R7: `irq_fast` is high whenever some qualified source is marked fast, whatever its priority.
- R8: Words 8 to 15 hold the priorities in reverse order. Word 15−k holds sources 8k to 8k+7, and source i sits in bits [4·(i mod 8)+3 : 4·(i mod 8)].
- R9: A write to word 20 replaces pending[63:32] and a write to word 21 replaces pending[31:0]. Both words read as 0.
- R10: Words 22/23 read pending & enable & ~type, and words 24/25 read pending & enable & type. Writes to words 16–19, to words 22–25 and to unmapped words change nothing.
- R11: Reading word 16 returns `{10'b0, src[5:0], 12'b0, prio[3:0]}` for the qualified normal source with the highest priority. Ties go to the higher index. The read clears that source's pending bit. It returns 32'hFFFFFFFF when no normal source is qualified.
- R12: Reading word 17 returns the index of the lowest-numbered qualified fast source and clears its pending bit. It returns 32'hFFFFFFFF when there is none.
- R13: Reset clears pending, enable, type, control and priorities, and sets the mask to 31. Unmapped words read as 0. Read data appears on `rdata` one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Interrupt source levels |
| req_wr | input | 1 | Write strobe |
| req_rd | input | 1 | Read strobe |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `req_rd` |
| irq_norm | output | 1 | Normal request line |
| irq_fast | output | 1 | Fast request line |

## Verification
The bench targets the following corner cases, each with the failure a wrong design would show:

- **Priority equal to the mask.** A design using ≥ instead of > would raise `irq_norm` at equality.
- **Mask of 31.** A design that skips the bypass would leave `irq_norm` low for every priority.
- **Arbitration ties.** Two normal sources are given equal priority. A resolver that favours low indices would return the wrong source first.
- **Higher priority at a lower index.** A later case puts the higher priority on the lower index, so an index-only resolver would also fail.
- **Acknowledge racing a rising input.** The read of word 16 lands in the same cycle as a rising input on the same source. A design that lets the edge win would leave that source pending.
- **Reverse word order and reads of write-only and force words.** Both are checked through reads. A swapped order or a leaking read would return wrong data.

// File: rtl/vic_core.sv
module vic_core #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       src_i,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rdata,
  output logic              irq_norm,
  output logic              irq_fast
);
  localparam int NSRC = 64;
  localparam int NPW  = NSRC / 8;
  localparam logic [31:0] CTRL_KEEP = 32'h017C_0000;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0),  A_MASK = ADDR_W'(1),
    A_ENN = ADDR_W'(2),  A_DISN = ADDR_W'(3),  A_ENH = ADDR_W'(4),  A_ENL = ADDR_W'(5),
    A_TYH = ADDR_W'(6),  A_TYL = ADDR_W'(7),  A_NVEC = ADDR_W'(16), A_FVEC = ADDR_W'(17),
    A_PDH = ADDR_W'(18), A_PDL = ADDR_W'(19), A_FRH = ADDR_W'(20), A_FRL = ADDR_W'(21),
    A_NPH = ADDR_W'(22), A_NPL = ADDR_W'(23), A_FPH = ADDR_W'(24), A_FPL = ADDR_W'(25);

  logic [NSRC-1:0] pend, en, ftype, src_q, pend_nx;
  logic [31:0]     ctrl;
  logic [4:0]      nmask;
  logic [31:0]     prio_w [NPW];
  logic [3:0]      pri [NSRC];

  wire [NSRC-1:0] qual = pend & en;
  wire [NSRC-1:0] nvec = qual & ~ftype;
  wire [NSRC-1:0] fvec = qual & ftype;
  wire [NSRC-1:0] rise = src_i & ~src_q;
  wire [NSRC-1:0] fall = ~src_i & src_q;
  wire            pri_hit = (req_addr[ADDR_W-1:3] == (ADDR_W-3)'(1));
  wire [2:0]      pri_sel = ~req_addr[2:0];

  for (genvar g = 0; g < NSRC; g++) begin : g_pri
    assign pri[g] = prio_w[g/8][(g%8)*4 +: 4];
  end

  logic       n_found, f_found, n_hit;
  logic [5:0] n_idx, f_idx;
  logic [3:0] n_pri;

  always_comb begin
    n_found = 1'b0; n_idx = '0; n_pri = '0; n_hit = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (nvec[i]) begin
        if (!n_found || pri[i] >= n_pri) begin
          n_found = 1'b1; n_idx = i[5:0]; n_pri = pri[i];
        end
        if ({1'b0, pri[i]} > nmask) n_hit = 1'b1;
      end
    end
    f_found = 1'b0; f_idx = '0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (fvec[i]) begin
        f_found = 1'b1; f_idx = i[5:0];
      end
    end
  end

  assign irq_norm = (nmask == 5'd31) ? |nvec : n_hit;
  assign irq_fast = |fvec;

  wire [31:0] nvec_word = n_found ? {10'd0, n_idx, 12'd0, n_pri} : 32'hFFFF_FFFF;
  wire [31:0] fvec_word = f_found ? {26'd0, f_idx} : 32'hFFFF_FFFF;

  always_comb begin
    pend_nx = (pend | rise) & ~fall;
    if (req_wr && req_addr == A_FRH) pend_nx[63:32] = req_wdata;
    if (req_wr && req_addr == A_FRL) pend_nx[31:0]  = req_wdata;
    if (req_rd && req_addr == A_NVEC && n_found) pend_nx[n_idx] = 1'b0;
    if (req_rd && req_addr == A_FVEC && f_found) pend_nx[f_idx] = 1'b0;
  end

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (pri_hit) rd_val = prio_w[pri_sel];
    else case (req_addr)
      A_CTRL: rd_val = ctrl;
      A_MASK: rd_val = {27'd0, nmask};
      A_ENH:  rd_val = en[63:32];
      A_ENL:  rd_val = en[31:0];
      A_TYH:  rd_val = ftype[63:32];
      A_TYL:  rd_val = ftype[31:0];
      A_NVEC: rd_val = nvec_word;
      A_FVEC: rd_val = fvec_word;
      A_PDH:  rd_val = pend[63:32];
      A_PDL:  rd_val = pend[31:0];
      A_NPH:  rd_val = nvec[63:32];
      A_NPL:  rd_val = nvec[31:0];
      A_FPH:  rd_val = fvec[63:32];
      A_FPL:  rd_val = fvec[31:0];
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0; en <= '0; ftype <= '0; src_q <= '0;
      ctrl <= '0; nmask <= 5'd31; rdata <= '0;
      for (int k = 0; k < NPW; k++) prio_w[k] <= '0;
    end else begin
      src_q <= src_i;
      pend  <= pend_nx;
      if (req_rd) rdata <= rd_val;
      if (req_wr) begin
        if (pri_hit) prio_w[pri_sel] <= req_wdata;
        else case (req_addr)
          A_CTRL: ctrl <= req_wdata & CTRL_KEEP;
          A_MASK: nmask <= req_wdata[4:0];
          A_ENN:  en[req_wdata[5:0]] <= 1'b1;
          A_DISN: en[req_wdata[5:0]] <= 1'b0;
          A_ENH:  en[63:32] <= req_wdata;
          A_ENL:  en[31:0]  <= req_wdata;
          A_TYH:  ftype[63:32] <= req_wdata;
          A_TYL:  ftype[31:0]  <= req_wdata;
          default: ;
        endcase
      end
    end
  end

  a_r2_enable_by_number: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_addr == A_ENN) |=> en[$past(req_wdata[5:0])]);
  a_r2_numbered_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && (req_addr == A_ENN || req_addr == A_DISN)) |=> rdata == 32'd0);
  a_r6_norm_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm |-> (|nvec));
  a_r11_empty_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && req_addr == A_NVEC && !(|nvec)) |=> rdata == 32'hFFFF_FFFF);
  a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_wr && req_addr == A_NVEC && n_found) |=> !pend[$past(n_idx)]);
  a_r12_fast_index: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && req_addr == A_FVEC && irq_fast) |=> rdata[31:6] == 26'd0);
  a_r12_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_wr && req_addr == A_FVEC && f_found) |=> !pend[$past(f_idx)]);
endmodule

// File: tb/vic_core_test.sv
module vic_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_i = '0;
  logic        req_wr = 1'b0, req_rd = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rdata;
  logic        irq_norm, irq_fast;

  vic_core #(.ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .req_wr(req_wr), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdata(rdata),
    .irq_norm(irq_norm), .irq_fast(irq_fast));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic mon_pend = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) mon_pend <= req_rd;
  always @(negedge clk) begin
    if (mon_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rdata === e, t, rdata, e);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk); req_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); req_rd = 1'b1; req_addr = a; exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); req_rd = 1'b0;
  endtask

  task automatic rd_src(input logic [7:0] a, input int s, input logic [31:0] e, input string tag);
    @(negedge clk); req_rd = 1'b1; req_addr = a; src_i[s] = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); req_rd = 1'b0;
  endtask

  task automatic set_src(input int s, input logic v);
    @(negedge clk); src_i[s] = v;
    @(negedge clk);
  endtask

  task automatic pin(input logic act, input logic exp, input string tag);
    check(act === exp, tag, {31'd0, act}, {31'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    rd(8'd1, 32'd31, "R13 mask reset");
    rd(8'd0, 32'd0, "R13 ctrl reset");
    rd(8'd5, 32'd0, "R13 enable reset");
    rd(8'd19, 32'd0, "R13 pending reset");
    rd(8'd16, 32'hFFFF_FFFF, "R11 empty normal vector");
    rd(8'd17, 32'hFFFF_FFFF, "R12 empty fast vector");
    rd(8'h30, 32'd0, "R13 unmapped read");
    pin(irq_norm, 1'b0, "R13 irq_norm reset");
    pin(irq_fast, 1'b0, "R13 irq_fast reset");
    // R4 control
    wr(8'd0, 32'hFFFF_FFFF);
    rd(8'd0, 32'h017C_0000, "R4 control keep bits");
    // R2 numbered enable
    wr(8'd2, 32'h0000_00C5);
    rd(8'd5, 32'h0000_0020, "R2 enable 5 via low 6 bits");
    wr(8'd2, 32'd40);
    rd(8'd4, 32'h0000_0100, "R3 enable high word");
    rd(8'd2, 32'd0, "R2 word 2 reads zero");
    wr(8'd3, 32'd5);
    rd(8'd5, 32'd0, "R2 disable 5");
    // R1 rising edge
    set_src(40, 1'b1);
    rd(8'd18, 32'h0000_0100, "R1 rise sets pending");
    rd(8'd19, 32'd0, "R3 pending low word");
    pin(irq_norm, 1'b1, "R5 mask 31 no masking");
    rd(8'd22, 32'h0000_0100, "R10 normal qualified view");
    // R6 threshold
    wr(8'd1, 32'd0);
    pin(irq_norm, 1'b0, "R6 prio 0 not above mask 0");
    wr(8'd10, 32'h3);
    pin(irq_norm, 1'b1, "R6 prio 3 above mask 0");
    rd(8'd10, 32'h3, "R8 priority word 10");
    wr(8'd1, 32'd3);
    pin(irq_norm, 1'b0, "R6 prio equal to mask");
    wr(8'd1, 32'd2);
    pin(irq_norm, 1'b1, "R6 prio above mask 2");
    wr(8'd1, 32'd31);
    pin(irq_norm, 1'b1, "R5 mask 31 again");
    // R11 arbitration
    wr(8'd14, 32'h30);
    wr(8'd2, 32'd9);
    set_src(9, 1'b1);
    rd(8'd16, 32'h0028_0003, "R11 tie goes to higher index");
    rd(8'd18, 32'd0, "R11 ack clears pending");
    rd(8'd19, 32'h0000_0200, "R1 other source pending");
    rd(8'd16, 32'h0009_0003, "R11 next winner");
    rd(8'd16, 32'hFFFF_FFFF, "R11 none left");
    pin(irq_norm, 1'b0, "R11 irq_norm low after acks");
    // R9 force
    wr(8'd21, 32'h0000_0200);
    wr(8'd20, 32'h0000_0100);
    rd(8'd19, 32'h0000_0200, "R9 force low");
    rd(8'd20, 32'd0, "R9 force reads zero");
    wr(8'd14, 32'h50);
    rd(8'd16, 32'h0009_0005, "R11 higher prio beats index");
    // R7/R12 fast
    wr(8'd2, 32'd0);
    wr(8'd7, 32'h0000_0201);
    rd(8'd6, 32'd0, "R3 type high");
    rd(8'd7, 32'h0000_0201, "R3 type low");
    wr(8'd21, 32'h0000_0201);
    pin(irq_fast, 1'b1, "R7 fast asserted");
    rd(8'd25, 32'h0000_0201, "R10 fast qualified view");
    rd(8'd23, 32'd0, "R10 normal view excludes fast");
    rd(8'd22, 32'h0000_0100, "R10 normal view high");
    rd(8'd17, 32'd0, "R12 lowest fast first");
    rd(8'd17, 32'd9, "R12 next fast");
    rd(8'd17, 32'hFFFF_FFFF, "R12 none left");
    pin(irq_fast, 1'b0, "R7 fast dropped");
    // R10 ignored writes
    wr(8'd18, 32'hFFFF_FFFF);
    wr(8'd24, 32'hFFFF_FFFF);
    wr(8'd16, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'd18, 32'h0000_0100, "R10 pending unchanged by ignored writes");
    rd(8'd19, 32'd0, "R10 pending low unchanged");
    rd(8'd5, 32'h0000_0201, "R10 enable unchanged");
    // R1 fall and ack-vs-rise
    set_src(40, 1'b0);
    rd(8'd18, 32'd0, "R1 fall clears pending");
    wr(8'd20, 32'h0000_0100);
    rd_src(8'd16, 40, 32'h0028_0003, "R1 ack during rise returns source");
    rd(8'd18, 32'd0, "R1 clear wins over rise");
    // R5 mask width
    wr(8'd1, 32'hFFFF_FFE5);
    rd(8'd1, 32'd5, "R5 mask 5 bits");
    // R8 layout
    wr(8'd8, 32'h1234_5678);
    rd(8'd8, 32'h1234_5678, "R8 word 8 readback");
    wr(8'd2, 32'd63);
    wr(8'd20, 32'h8000_0000);
    rd(8'd16, 32'h003F_0001, "R8 source 63 in top nibble of word 8");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule